// File: doc/BRIEF.md
# Three-Valued Fault-Injectable Gate Cell

This block is one logic cell that operates on three-valued signals: 0, 1 and unknown. A type code picks the gate function. The choices are AND (under two codes), OR, a zero-delay joining point that acts as OR, an AND with one active-low input, a tri-state pass gate with an enable, an inverter, and a fixed one-step buffer. The result passes through a delay line that advances only on time steps. Between steps the output holds its last value.

Stuck-at faults can be placed on any input pin or on the output. The type and delay settings are captured while reset is held, so the delay line never mixes results from two configurations. The cell is meant to be instantiated many times in a fault-simulation model of a larger circuit.

Top module: `tv_gate_cell`

## Requirements
- R1: Pin values use a 2-bit code: 2'b00 means 0, 2'b01 means 1 and 2'b10 means unknown. The code 2'b11 on any data pin or fault-value pin is treated as unknown, and the output never shows 2'b11.
- R2: Type codes 0 and 1 both act as AND over all pins. Any 0 gives 0. All 1 gives 1. Otherwise the result is unknown.
- R3: Type code 2 acts as OR over all pins. Any 1 gives 1. All 0 gives 0. Otherwise the result is unknown.
- R4: Type code 3 acts as OR and always uses zero delay, whatever the delay setting is.
- R5: Type code 4 takes pin 0 as data and pin 1 as an active-low qualifier. A qualifier of 1 gives 0. A qualifier of 0 passes the data. An unknown qualifier gives 0 when the data is 0 and unknown otherwise.
- R6: Type code 5 takes pin 0 as data and pin 1 as enable. An enable of 1 passes the data. An enable of 0 or unknown gives unknown.
- R7: Type code 6 inverts pin 0. The inverse of unknown is unknown.
- R8: With delay D, the output after the k-th step edge equals the result of the pins sampled at step edge k-D. With D of 0, the output takes the result of the pins sampled at that same edge.
- R9: Type code 7 copies pin 0 with a delay of exactly one step, whatever the delay setting is.
- R10: Reset makes the output and every stored result unknown. No result computed before the reset ever reaches the output.
- R11: When the step enable is low at a clock edge, the output does not change, whatever the pins do.
- R12: An enabled input fault replaces that pin's value with the fault value before evaluation.
- R13: An enabled output fault drives the fault value onto the output in the same cycle, whatever the inputs and the stored state are. Releasing the fault shows the held value again.
- R14: The type and delay settings are captured only while reset is high. Changes made at other times have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; captures the type and delay settings |
| step_en | input | 1 | Advances one time step at this clock edge |
| pin_val | input | 2*N_IN | Encoded input pins, pin i in bits [2i+1:2i] |
| gate_sel | input | 3 | Gate type code |
| delay_sel | input | DW | Delay in steps, 0 to MAX_DELAY |
| pin_flt_en | input | N_IN | Per-pin stuck-at enable |
| pin_flt_val | input | 2*N_IN | Per-pin stuck-at value |
| out_flt_en | input | 1 | Output stuck-at enable |
| out_flt_val | input | 2 | Output stuck-at value |
| out_val | output | 2 | Encoded cell output |

## Verification
Two functions can act in the same cycle. The first is the output fault override, which acts without a clock edge. The second is the step update of the held output, which happens underneath the override. The bench applies an output fault, then steps new pins in while the fault is still on, so the held value changes while hidden. It then checks that the output matches the fault value during the fault, and matches the newly stepped result at once when the fault is released. A second overlap occurs when reset and stored results meet: the bench resets in the middle of a delayed stream and checks that only unknown appears until the new inputs have travelled the full delay.

// File: rtl/tv_pkg.sv
package tv_pkg;

   typedef logic [1:0] tv_t;

   localparam tv_t TV_ZERO = 2'b00;
   localparam tv_t TV_ONE  = 2'b01;
   localparam tv_t TV_UNK  = 2'b10;

   typedef enum logic [2:0] {
      GT_AND    = 3'd0,
      GT_AND_B  = 3'd1,
      GT_OR     = 3'd2,
      GT_JOIN   = 3'd3,
      GT_ANDN   = 3'd4,
      GT_TRI    = 3'd5,
      GT_INV    = 3'd6,
      GT_STEP1  = 3'd7
   } gate_e;

   // Map the illegal code onto unknown.
   function automatic tv_t tv_clean(input tv_t v);
      return (v == 2'b11) ? TV_UNK : v;
   endfunction

   function automatic tv_t tv_inv(input tv_t v);
      case (v)
         TV_ZERO: return TV_ONE;
         TV_ONE:  return TV_ZERO;
         default: return TV_UNK;
      endcase
   endfunction

endpackage

// File: rtl/tv_pin_cond.sv
module tv_pin_cond
   import tv_pkg::*;
#(
   parameter int N_IN = 4
) (
   input  logic [2*N_IN-1:0] raw,
   input  logic [N_IN-1:0]   flt_en,
   input  logic [2*N_IN-1:0] flt_val,
   output logic [2*N_IN-1:0] pins
);

   for (genvar g = 0; g < N_IN; g++) begin : g_pin
      tv_t picked;
      assign picked = flt_en[g] ? flt_val[2*g +: 2] : raw[2*g +: 2];
      assign pins[2*g +: 2] = tv_clean(picked);
   end

endmodule

// File: rtl/tv_eval.sv
module tv_eval
   import tv_pkg::*;
#(
   parameter int N_IN = 4
) (
   input  logic [2*N_IN-1:0] pins,
   input  gate_e             kind,
   output tv_t               res
);

   logic any_zero, any_one, any_unk;
   tv_t  dat, ctl;

   assign dat = pins[1:0];
   assign ctl = pins[3:2];

   always_comb begin
      any_zero = 1'b0;
      any_one  = 1'b0;
      any_unk  = 1'b0;
      for (int k = 0; k < N_IN; k++) begin
         if (pins[2*k +: 2] == TV_ZERO) any_zero = 1'b1;
         if (pins[2*k +: 2] == TV_ONE)  any_one  = 1'b1;
         if (pins[2*k +: 2] == TV_UNK)  any_unk  = 1'b1;
      end
   end

   always_comb begin
      res = TV_UNK;
      case (kind)
         GT_AND, GT_AND_B:
            res = any_zero ? TV_ZERO : (any_unk ? TV_UNK : TV_ONE);
         GT_OR, GT_JOIN:
            res = any_one ? TV_ONE : (any_unk ? TV_UNK : TV_ZERO);
         GT_ANDN: begin
            if (ctl == TV_ONE)       res = TV_ZERO;
            else if (ctl == TV_ZERO) res = dat;
            else                     res = (dat == TV_ZERO) ? TV_ZERO : TV_UNK;
         end
         GT_TRI:
            res = (ctl == TV_ONE) ? dat : TV_UNK;
         GT_INV:
            res = tv_inv(dat);
         GT_STEP1:
            res = dat;
         default:
            res = TV_UNK;
      endcase
   end

endmodule

// File: rtl/tv_delay_line.sv
module tv_delay_line
   import tv_pkg::*;
#(
   parameter int MAX_DELAY = 7,
   parameter int DW        = $clog2(MAX_DELAY + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          adv,
   input  tv_t           din,
   input  logic [DW-1:0] tap_sel,
   output tv_t           dout
);

   // stg[k] holds the result from k+1 steps back.
   tv_t stg [MAX_DELAY];
   tv_t tap;

   for (genvar g = 0; g < MAX_DELAY; g++) begin : g_stage
      if (g == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (rst)      stg[0] <= TV_UNK;
            else if (adv) stg[0] <= din;
         end
      end else begin : g_body
         always_ff @(posedge clk) begin
            if (rst)      stg[g] <= TV_UNK;
            else if (adv) stg[g] <= stg[g-1];
         end
      end
   end

   always_comb begin
      tap = din;
      for (int k = 1; k <= MAX_DELAY; k++) begin
         if (int'(tap_sel) == k) tap = stg[k-1];
      end
   end

   always_ff @(posedge clk) begin
      if (rst)      dout <= TV_UNK;
      else if (adv) dout <= tap;
   end

endmodule

// File: rtl/tv_gate_cell.sv
module tv_gate_cell
   import tv_pkg::*;
#(
   parameter  int N_IN      = 4,
   parameter  int MAX_DELAY = 7,
   localparam int DW        = $clog2(MAX_DELAY + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              step_en,
   input  logic [2*N_IN-1:0] pin_val,
   input  logic [2:0]        gate_sel,
   input  logic [DW-1:0]     delay_sel,
   input  logic [N_IN-1:0]   pin_flt_en,
   input  logic [2*N_IN-1:0] pin_flt_val,
   input  logic              out_flt_en,
   input  logic [1:0]        out_flt_val,
   output logic [1:0]        out_val
);

   if (N_IN < 2) begin : g_bad_pins
      $error("tv_gate_cell: N_IN must be at least 2");
   end
   if (MAX_DELAY < 1) begin : g_bad_depth
      $error("tv_gate_cell: MAX_DELAY must be at least 1");
   end

   localparam logic [DW-1:0] DLY_CAP = DW'(MAX_DELAY);

   gate_e             cfg_type;
   logic [DW-1:0]     cfg_delay;
   logic [DW-1:0]     eff_delay;
   logic [2*N_IN-1:0] pins;
   tv_t               result;
   tv_t               held;

   // Configuration is latched only while reset is asserted.
   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_type  <= gate_e'(gate_sel);
         cfg_delay <= delay_sel;
      end
   end

   always_comb begin
      case (cfg_type)
         GT_JOIN:  eff_delay = '0;
         GT_STEP1: eff_delay = DW'(1);
         default:  eff_delay = (cfg_delay > DLY_CAP) ? DLY_CAP : cfg_delay;
      endcase
   end

   tv_pin_cond #(.N_IN(N_IN)) u_cond (
      .raw     (pin_val),
      .flt_en  (pin_flt_en),
      .flt_val (pin_flt_val),
      .pins    (pins)
   );

   tv_eval #(.N_IN(N_IN)) u_eval (
      .pins (pins),
      .kind (cfg_type),
      .res  (result)
   );

   tv_delay_line #(.MAX_DELAY(MAX_DELAY), .DW(DW)) u_line (
      .clk     (clk),
      .rst     (rst),
      .adv     (step_en),
      .din     (result),
      .tap_sel (eff_delay),
      .dout    (held)
   );

   assign out_val = out_flt_en ? tv_clean(out_flt_val) : held;

endmodule

// File: rtl/tv_gate_cell_chk.sv
module tv_gate_cell_chk #(
   parameter int DW = 3
) (
   input logic          clk,
   input logic          rst,
   input logic          step_en,
   input logic          out_flt_en,
   input logic [1:0]    out_flt_val,
   input logic [1:0]    out_val,
   input logic [2:0]    cfg_type,
   input logic [DW-1:0] cfg_delay
);

   logic armed = 1'b0;
   logic armed_d = 1'b0;

   always_ff @(posedge clk) begin
      if (rst) armed <= 1'b1;
      armed_d <= armed;
   end

   AST_LEGAL_OUT: assert property (@(posedge clk) disable iff (rst)
      armed |-> out_val != 2'b11);  // R1

   AST_RESET_UNKNOWN: assert property (@(posedge clk) disable iff (rst)
      (armed_d && $past(rst) && !out_flt_en) |-> out_val == 2'b10);  // R10

   AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (rst)
      (armed_d && !$past(rst) && !$past(step_en) && !out_flt_en && !$past(out_flt_en))
         |-> out_val == $past(out_val));  // R11

   AST_OUT_FAULT: assert property (@(posedge clk) disable iff (rst)
      (armed && out_flt_en && out_flt_val != 2'b11) |-> out_val == out_flt_val);  // R13

   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
      (armed_d && !$past(rst)) |-> ($stable(cfg_type) && $stable(cfg_delay)));  // R14

endmodule

bind tv_gate_cell tv_gate_cell_chk #(.DW(DW)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .step_en     (step_en),
   .out_flt_en  (out_flt_en),
   .out_flt_val (out_flt_val),
   .out_val     (out_val),
   .cfg_type    (cfg_type),
   .cfg_delay   (cfg_delay)
);

// File: tb/tv_gate_cell_bench.sv
module tv_gate_cell_bench;

   localparam int N_IN = 4;
   localparam int DW   = 3;

   localparam logic [1:0] Z = 2'b00;
   localparam logic [1:0] O = 2'b01;
   localparam logic [1:0] U = 2'b10;
   localparam logic [1:0] X = 2'b11;

   // {type, pin3, pin2, pin1, pin0, expected}, evaluated with delay 0
   localparam int NV = 29;
   localparam logic [12:0] VEC [NV] = '{
      {3'd0, O, O, O, O, O},
      {3'd0, O, O, Z, O, Z},
      {3'd0, O, U, O, O, U},
      {3'd0, Z, U, U, U, Z},
      {3'd0, X, O, O, O, U},
      {3'd1, O, O, O, O, O},
      {3'd1, O, O, U, Z, Z},
      {3'd2, Z, Z, Z, Z, Z},
      {3'd2, Z, U, Z, O, O},
      {3'd2, Z, Z, U, Z, U},
      {3'd2, U, U, U, O, O},
      {3'd2, Z, Z, Z, X, U},
      {3'd3, Z, Z, Z, Z, Z},
      {3'd3, Z, O, Z, Z, O},
      {3'd4, U, U, O, O, Z},
      {3'd4, U, U, Z, O, O},
      {3'd4, U, U, Z, U, U},
      {3'd4, U, U, Z, Z, Z},
      {3'd4, U, U, U, Z, Z},
      {3'd4, U, U, U, O, U},
      {3'd5, U, U, O, Z, Z},
      {3'd5, U, U, O, O, O},
      {3'd5, U, U, Z, O, U},
      {3'd5, U, U, U, Z, U},
      {3'd6, U, U, U, Z, O},
      {3'd6, U, U, U, O, Z},
      {3'd6, U, U, U, U, U},
      {3'd6, O, O, X, X, U},
      {3'd6, Z, Z, Z, O, Z}
   };

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              step_en = 1'b0;
   logic [2*N_IN-1:0] pin_val = '0;
   logic [2:0]        gate_sel = '0;
   logic [DW-1:0]     delay_sel = '0;
   logic [N_IN-1:0]   pin_flt_en = '0;
   logic [2*N_IN-1:0] pin_flt_val = '0;
   logic              out_flt_en = 1'b0;
   logic [1:0]        out_flt_val = '0;
   logic [1:0]        out_val;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   tv_gate_cell #(.N_IN(N_IN), .MAX_DELAY(7)) u_tv_gate_cell (
      .clk, .rst, .step_en, .pin_val, .gate_sel, .delay_sel,
      .pin_flt_en, .pin_flt_val, .out_flt_en, .out_flt_val, .out_val
   );

   task automatic check(input string req, input logic [1:0] exp);
      checks++;
      if (out_val !== exp) begin
         errors++;
         $display("FAIL %s: out_val=%b expected=%b at %0t", req, out_val, exp, $time);
      end
   endtask

   // All tasks start and end just after a falling edge.
   task automatic do_reset(input logic [2:0] t, input logic [DW-1:0] d);
      rst = 1'b1; gate_sel = t; delay_sel = d; step_en = 1'b0;
      @(posedge clk); @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic step();
      step_en = 1'b1;
      @(posedge clk); @(negedge clk);
      step_en = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk); @(negedge clk);
      end
   endtask

   function automatic string tag_of(input logic [2:0] t);
      case (t)
         3'd0, 3'd1: return "R2";
         3'd2:       return "R3";
         3'd3:       return "R4";
         3'd4:       return "R5";
         3'd5:       return "R6";
         default:    return "R7";
      endcase
   endfunction

   initial begin
      int cur;
      cur = -1;
      @(negedge clk);
      do_reset(3'd0, 3'd0);
      check("R10 reset state", U);

      for (int i = 0; i < NV; i++) begin
         if (int'(VEC[i][12:10]) != cur) begin
            do_reset(VEC[i][12:10], 3'd0);
            cur = int'(VEC[i][12:10]);
         end
         pin_val = VEC[i][9:2];
         step();
         check(tag_of(VEC[i][12:10]), VEC[i][1:0]);
      end

      // R1: illegal code on a pin of OR with others 0
      do_reset(3'd2, 3'd0);
      pin_val = {Z, X, Z, Z}; step();
      check("R1 illegal code as unknown", U);

      // R8: delay of three steps
      do_reset(3'd0, 3'd3);
      pin_val = {O, O, O, O}; step(); check("R8 step1", U);
      pin_val = {O, Z, O, O}; step(); check("R8 step2", U);
      pin_val = {O, O, O, O}; step(); check("R8 step3", U);
      pin_val = {Z, Z, Z, Z}; step(); check("R8 step4", O);
      step(); check("R8 step5", Z);
      step(); check("R8 step6", O);

      // R11: no step, pins change, output holds
      pin_val = {O, O, O, O};
      idle(3);
      check("R11 hold without step", O);

      // R10: reset in the middle of a delayed stream
      do_reset(3'd0, 3'd3);
      pin_val = {O, O, O, O};
      step(); check("R10 flushed step1", U);
      step(); check("R10 flushed step2", U);
      step(); check("R10 flushed step3", U);
      step(); check("R10 new result arrives", O);

      // R4: joining point ignores delay setting
      do_reset(3'd3, 3'd5);
      pin_val = {Z, Z, O, Z}; step(); check("R4 zero delay one", O);
      pin_val = {Z, Z, Z, Z}; step(); check("R4 zero delay zero", Z);

      // R9: fixed one-step buffer ignores delay setting
      do_reset(3'd7, 3'd4);
      pin_val = {U, U, U, O}; step(); check("R9 first step", U);
      pin_val = {U, U, U, Z}; step(); check("R9 second step", O);
      step(); check("R9 third step", Z);

      // R12: input stuck-at
      do_reset(3'd0, 3'd0);
      pin_val = {O, O, O, O};
      pin_flt_en = 4'b0100; pin_flt_val = {U, Z, U, U};
      step(); check("R12 pin2 stuck at 0", Z);
      pin_val = {O, O, O, Z};
      pin_flt_en = 4'b0001; pin_flt_val = {U, U, U, O};
      step(); check("R12 pin0 stuck at 1", O);
      pin_flt_en = '0;

      // R13: output stuck-at, combined with a hidden step
      out_flt_en = 1'b1; out_flt_val = Z;
      #1 check("R13 immediate override", Z);
      pin_val = {O, Z, O, O};
      out_flt_val = O;
      step(); check("R13 override during step", O);
      out_flt_en = 1'b0;
      #1 check("R13 release shows stepped value", Z);
      out_flt_en = 1'b1; out_flt_val = X;
      #1 check("R13 illegal fault value as unknown", U);
      out_flt_en = 1'b0;
      @(negedge clk);

      // R14: settings changed outside reset are ignored
      do_reset(3'd0, 3'd0);
      gate_sel = 3'd2; delay_sel = 3'd5;
      pin_val = {Z, Z, Z, O};
      step(); check("R14 type and delay kept", Z);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: out_val=%b expected=finish", out_val);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule